// File: doc/BRIEF.md
# DMA Staging FIFO with Threshold-Gated Write Requests

This block sits between the read side and the write side of one DMA channel. Read beats returned from the source land in an internal FIFO, and write beats leave it toward the destination. The block decides, after every clock edge, whether the channel should ask the bus for more source reads and whether it should ask for destination writes. The bus protocol and descriptor handling belong to other blocks.

Reads are requested only while the block still has source beats to fetch and the FIFO has room for one whole burst. Writes follow one of two rules. In single-beat mode a write is requested as soon as one beat is held. In burst modes writes are held back until the fill level reaches a programmed threshold. If the source side finishes early, a drain is forced. Once a write phase starts it runs until the FIFO is empty. After that the block re-arms and waits for the threshold again, unless reads are complete.

All outputs are registered. After each rising edge they reflect the FIFO level that results from that edge's push and pop, and the `reads_done` value sampled at that edge. Configuration is expected to stay stable during a block.

Top module: `xfer_fifo_gate`

## Requirements
- R1: While `rst` is high, `level`, `rd_req`, `wr_req`, `blk_done` and `err` are all 0 after each clock edge.
- R2: `cfg_burst` selects the burst length (0: 1 beat, 1: 4, 2: 8, 3: 16). `rd_req` is 1 exactly when `reads_done` was 0 at the edge and DEPTH minus `level` is at least the burst length.
- R3: With `cfg_burst` = 0, `wr_req` is 1 whenever `level` is at least 1.
- R4: `cfg_thresh` selects the threshold (0: 1 beat, 1: 2, 2: 4, 3: 8). With `cfg_burst` nonzero and `reads_done` 0, an idle write side raises `wr_req` only once `level` reaches the threshold.
- R5: When `reads_done` is 1 and `level` is nonzero but below the threshold, `wr_req` rises anyway to drain the FIFO.
- R6: Once `wr_req` is 1, it stays 1 while `level` is nonzero, even when `level` falls below the threshold.
- R7: When `level` reaches 0, `wr_req` drops. While `reads_done` is 0 it stays low until the threshold is reached again.
- R8: `blk_done` is 1 exactly when `reads_done` was 1 at the edge and `level` is 0.
- R9: Beats leave in the order they arrived. `pop_data` holds the popped beat from the edge of the pop until the next pop.
- R10: A push when `level` equals DEPTH, or a pop when `level` is 0, is ignored (level and contents unchanged) and sets `err`. `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst | input | 2 | Burst length code |
| cfg_thresh | input | 2 | Write threshold code |
| reads_done | input | 1 | All source reads of the block have been issued and returned |
| push | input | 1 | Write one read beat into the FIFO |
| push_data | input | WIDTH | Beat to store |
| pop | input | 1 | Take one beat toward the destination |
| pop_data | output | WIDTH | Beat taken by the last pop |
| level | output | $clog2(DEPTH+1) | Beats currently held |
| rd_req | output | 1 | Request the bus for a source read burst |
| wr_req | output | 1 | Request the bus for destination writes |
| blk_done | output | 1 | Reads complete and FIFO empty |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
On every cycle the assertions check four things. A read request always leaves room for a burst. No write is requested from an empty FIFO. A started write phase holds while data remains, and a write phase only begins below the threshold when reads were complete. They also check that the done flag implies an empty FIFO and that the error flag never clears by itself. What the assertions cannot show needs the bench's scenarios: the exact threshold and burst decode values, the forced drain and re-arm sequences, data ordering through the storage array, and that an overflowing push or underflowing pop leaves the contents intact.

// File: rtl/xfg_pkg.sv
package xfg_pkg;

  function automatic int burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int thresh_beats(input logic [1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/xfg_store.sv
module xfg_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/xfg_level.sv
module xfg_level #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count_nxt,
  output logic [CW-1:0] count_q,
  output logic          err_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_comb begin
    push_ok   = push && (count_q != FULL);
    pop_ok    = pop && (count_q != '0);
    count_nxt = count_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_nxt;
      if ((push && !push_ok) || (pop && !pop_ok)) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/xfg_gate.sv
module xfg_gate
  import xfg_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cfg_burst,
  input  logic [1:0]    cfg_thresh,
  input  logic          reads_done,
  input  logic [CW-1:0] count_nxt,
  output logic          rd_req,
  output logic          wr_req,
  output logic          blk_done
);
  int   arm_lvl;
  logic has_data, wr_nxt, rd_nxt, done_nxt;

  always_comb begin
    // single-beat mode arms on any data; burst modes arm on the threshold
    arm_lvl  = (cfg_burst == 2'd0) ? 1 : thresh_beats(cfg_thresh);
    has_data = (count_nxt != '0);
    if (wr_req) wr_nxt = has_data;
    else        wr_nxt = has_data && (reads_done || int'(count_nxt) >= arm_lvl);
    rd_nxt   = !reads_done && ((DEPTH - int'(count_nxt)) >= burst_beats(cfg_burst));
    done_nxt = reads_done && !has_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      blk_done <= 1'b0;
    end else begin
      rd_req   <= rd_nxt;
      wr_req   <= wr_nxt;
      blk_done <= done_nxt;
    end
  end
endmodule

// File: rtl/xfer_fifo_gate.sv
module xfer_fifo_gate #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 cfg_burst,
  input  logic [1:0]                 cfg_thresh,
  input  logic                       reads_done,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           pop_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       rd_req,
  output logic                       wr_req,
  output logic                       blk_done,
  output logic                       err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          push_ok, pop_ok;
  logic [CW-1:0] count_nxt;

  xfg_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .count_nxt(count_nxt), .count_q(level), .err_q(err)
  );

  xfg_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(push_ok), .wr_data(push_data),
    .rd_en(pop_ok), .rd_data(pop_data)
  );

  xfg_gate #(.DEPTH(DEPTH), .CW(CW)) u_gate (
    .clk(clk), .rst(rst), .cfg_burst(cfg_burst), .cfg_thresh(cfg_thresh),
    .reads_done(reads_done), .count_nxt(count_nxt),
    .rd_req(rd_req), .wr_req(wr_req), .blk_done(blk_done)
  );
endmodule

// File: rtl/xfg_checker.sv
module xfg_checker
  import xfg_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    cfg_burst,
  input logic [1:0]    cfg_thresh,
  input logic          reads_done,
  input logic          pop,
  input logic [CW-1:0] level,
  input logic          rd_req,
  input logic          wr_req,
  input logic          blk_done,
  input logic          err
);
  p_rd_room_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && $stable(cfg_burst)) |-> (int'(level) + burst_beats(cfg_burst) <= DEPTH));

  p_thresh_gate_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_req) && !$past(reads_done) && !$past(pop) && $past(cfg_burst) != 2'd0)
      |-> (int'(level) >= thresh_beats($past(cfg_thresh))));

  p_drain_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_req && level > CW'(1)) |=> wr_req);

  p_empty_no_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !wr_req);

  p_done_empty_r8: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> (level == '0 && !rd_req));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind xfer_fifo_gate xfg_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_burst(cfg_burst), .cfg_thresh(cfg_thresh),
  .reads_done(reads_done), .pop(pop), .level(level), .rd_req(rd_req),
  .wr_req(wr_req), .blk_done(blk_done), .err(err)
);

// File: tb/xfer_fifo_gate_tb.sv
module xfer_fifo_gate_tb;
  localparam int W  = 32;
  localparam int D  = 32;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_burst = 2'd1, cfg_thresh = 2'd2;
  logic reads_done = 1'b0, push = 1'b0, pop = 1'b0;
  logic [W-1:0] push_data = '0, pop_data;
  logic [CW-1:0] level;
  logic rd_req, wr_req, blk_done, err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  xfer_fifo_gate #(.WIDTH(W), .DEPTH(D)) u_dut (.*);

  typedef struct packed {
    logic [1:0] burst; logic [1:0] thr; logic rdone; logic psh; logic pp;
    logic [5:0] lvl; logic rd; logic wr; logic done;
  } vec_t;

  // burst code 1 = 4 beats, threshold code 2 = 4 beats, then single-beat mode
  localparam vec_t TBL [15] = '{
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b0, 1'b0},  // R4 below thr
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 1'b1, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd3, 1'b1, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd4, 1'b1, 1'b1, 1'b0},  // R4 reached
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd3, 1'b1, 1'b1, 1'b0},  // R6
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd2, 1'b1, 1'b1, 1'b0},
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd1, 1'b1, 1'b1, 1'b0},
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0},  // R7 empty
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b0, 1'b0},  // R7 re-armed
    '{2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 6'd2, 1'b1, 1'b0, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 6'd2, 1'b0, 1'b1, 1'b0},  // R5 forced drain
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 6'd1, 1'b0, 1'b1, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b0, 1'b1, 6'd0, 1'b0, 1'b0, 1'b1},  // R8
    '{2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b1, 1'b0},  // R3
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] b, input logic [1:0] t, input logic rd,
                      input logic pu, input logic po, input logic [W-1:0] dat);
    @(negedge clk);
    cfg_burst = b; cfg_thresh = t; reads_done = rd;
    push = pu; pop = po; push_data = dat;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push = 1'b0; pop = 1'b0; reads_done = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset outputs", {27'd0, 1'(level != 0), rd_req, wr_req, blk_done, err}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, '0);

    // table walk
    foreach (TBL[i]) begin
      step(TBL[i].burst, TBL[i].thr, TBL[i].rdone, TBL[i].psh, TBL[i].pp, W'(32'hC000 + i));
      check($sformatf("R2-R8 row %0d level", i), 32'(level), 32'(TBL[i].lvl));
      check($sformatf("R2 row %0d rd_req", i), 32'(rd_req), 32'(TBL[i].rd));
      check($sformatf("R4 row %0d wr_req", i), 32'(wr_req), 32'(TBL[i].wr));
      check($sformatf("R8 row %0d blk_done", i), 32'(blk_done), 32'(TBL[i].done));
    end

    // R2 / R4: 16-beat bursts, threshold 8, fill to 17
    do_reset();
    for (int i = 1; i <= 17; i++) begin
      step(2'd3, 2'd3, 1'b0, 1'b1, 1'b0, W'(32'hA000 + i));
      check("R2 rd_req vs free space", 32'(rd_req), 32'(i <= 16));
      check("R4 wr_req vs threshold 8", 32'(wr_req), 32'(i >= 8));
    end
    // R9 / R6: drain in order, request held down to empty
    for (int i = 1; i <= 17; i++) begin
      step(2'd3, 2'd3, 1'b0, 1'b0, 1'b1, '0);
      check("R9 pop order", pop_data, W'(32'hA000 + i));
      check("R6 drain holds", 32'(wr_req), 32'(i < 17));
    end
    // R2: 8-beat mode, reads done blocks read requests
    step(2'd2, 2'd1, 1'b1, 1'b0, 1'b0, '0);
    check("R2 rd_req low when reads done", 32'(rd_req), 32'd0);
    check("R8 done when empty", 32'(blk_done), 32'd1);
    step(2'd2, 2'd1, 1'b0, 1'b1, 1'b0, W'(32'h77));
    check("R4 thr 2 not yet", 32'(wr_req), 32'd0);
    step(2'd2, 2'd1, 1'b0, 1'b1, 1'b0, W'(32'h78));
    check("R4 thr 2 reached", 32'(wr_req), 32'd1);

    // R10 underflow
    do_reset();
    step(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, '0);
    check("R10 underflow err", 32'(err), 32'd1);
    check("R10 underflow level", 32'(level), 32'd0);
    step(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, '0);
    check("R10 err sticky", 32'(err), 32'd1);

    // R10 overflow
    do_reset();
    for (int i = 0; i < D; i++) step(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, W'(32'hB000 + i));
    check("R10 full no err", 32'(err), 32'd0);
    check("R2 full rd_req low", 32'(rd_req), 32'd0);
    step(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, W'(32'hBFFF));
    check("R10 overflow err", 32'(err), 32'd1);
    check("R10 overflow level", 32'(level), 32'(D));
    for (int i = 0; i < D; i++) begin
      step(2'd0, 2'd0, 1'b0, 1'b0, 1'b1, '0);
      if (i == 0 || i == D - 1) check("R10 contents intact", pop_data, W'(32'hB000 + i));
    end
    check("R3 empty after drain", 32'(wr_req), 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule